// File: doc/BRIEF.md
# Chip-Level Interrupt Aggregator

This block collects a set of system interrupt request lines from peripherals across a chip. It folds them onto a smaller set of host interrupt lines that feed each core's local interrupt selector. A rising edge on a system line latches a pending bit for that line. Each system line carries a programmable channel number. Channels correspond one-to-one with host outputs, so there is no second mapping stage. A host output is the OR of all enabled pending bits routed to it. That OR is gated by a per-host enable and by one global enable.

Software drives the block through a single-cycle command port. The operation code selects the action, and the index and value fields supply its operands. The available actions set or clear a system enable, clear a pending bit, write a channel number, set or clear a host enable, and switch the global enable on or off. There is no priority, nesting or vector logic. Every channel is a plain OR, and the receiving core decides what to service first. The pending bits are also visible as a raw status vector.

Top module: `cic_aggregator`

## Requirements
- R1: After reset all pending bits and host outputs are 0, every system and host enable is off, every channel number is 0, and the global enable is on.
- R2: A 0-to-1 transition on system input i, seen between two consecutive clock edges, sets pending bit i at the next edge. A line that stays high does not set the bit again once it has been cleared.
- R3: Command op 2 (pending clear) with index i clears only pending bit i at the next edge.
- R4: If an input edge and a pending clear for the same index fall on the same edge, the pending bit ends up set.
- R5: Command op 3 writes the value field as the channel number of system input idx. Host output h is driven only by inputs whose channel number equals h.
- R6: When several inputs share one channel, that host output stays high while any of them is enabled and pending.
- R7: Op 0 sets and op 1 clears the enable of system input idx. A disabled input still latches its pending bit but does not drive any host output.
- R8: Op 4 sets and op 5 clears the enable of host output idx. A disabled host output stays low whatever is pending.
- R9: Op 7 turns the global enable off, forcing every host output low in one command. Op 6 turns it back on and restores the outputs from the state that was held.
- R10: A channel number of N_HOST or more routes its input to no host output. A command whose index is out of range for its target changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_irq_i | input | N_SYS | System interrupt request lines |
| cfg_we | input | 1 | Command strobe, one command per cycle |
| cfg_op | input | 3 | Command operation code (0..7 as in the requirements) |
| cfg_idx | input | IDX_W | System or host index for the command |
| cfg_val | input | CH_W | Channel number for op 3 |
| sys_pend_o | output | N_SYS | Raw pending bits |
| host_irq_o | output | N_HOST | Host interrupt outputs |

## Verification
The bench sweeps every input against every channel code, including the codes above the host count. A design that wrapped or truncated the channel number would light a real host line where none is expected. It aims a clear and a fresh edge at the same bit on the same cycle; a design that let the clear win would lose that interrupt. It keeps an input held high across a clear, which catches a level-sensitive latch that re-pends the bit forever. It also shares a channel among three inputs and retires them one by one, checking that the output drops only after the last. Finally, it toggles the enables of sources that are still pending, so that a design gating the latch itself instead of the output shows up as a missing status bit.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef enum logic [2:0] {
    OP_SEN_SET  = 3'd0,
    OP_SEN_CLR  = 3'd1,
    OP_PEND_CLR = 3'd2,
    OP_MAP      = 3'd3,
    OP_HEN_SET  = 3'd4,
    OP_HEN_CLR  = 3'd5,
    OP_GLB_ON   = 3'd6,
    OP_GLB_OFF  = 3'd7
  } cfg_op_e;

  function automatic int unsigned max_int(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cic_cfg_regs.sv
module cic_cfg_regs #(
  parameter int N_SYS  = 8,
  parameter int N_HOST = 5,
  parameter int IDX_W  = 3,
  parameter int CH_W   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [2:0]                   cfg_op,
  input  logic [IDX_W-1:0]             cfg_idx,
  input  logic [CH_W-1:0]              cfg_val,
  output logic [N_SYS-1:0]             sys_en,
  output logic [N_SYS-1:0][CH_W-1:0]   chan_map,
  output logic [N_HOST-1:0]            host_en,
  output logic                         glob_en,
  output logic [N_SYS-1:0]             clr_vec
);
  import cic_pkg::*;

  logic [N_SYS-1:0]  sys_hit;
  logic [N_HOST-1:0] host_hit;
  cfg_op_e           op;

  assign op = cfg_op_e'(cfg_op);

  for (genvar i = 0; i < N_SYS; i++) begin : g_sys_dec
    assign sys_hit[i] = cfg_we && (cfg_idx == IDX_W'(i));
  end
  for (genvar h = 0; h < N_HOST; h++) begin : g_host_dec
    assign host_hit[h] = cfg_we && (cfg_idx == IDX_W'(h));
  end

  assign clr_vec = (op == OP_PEND_CLR) ? sys_hit : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_en   <= '0;
      chan_map <= '0;
      host_en  <= '0;
      glob_en  <= 1'b1;
    end else if (cfg_we) begin
      for (int i = 0; i < N_SYS; i++) begin
        if (sys_hit[i]) begin
          if (op == OP_SEN_SET) sys_en[i] <= 1'b1;
          if (op == OP_SEN_CLR) sys_en[i] <= 1'b0;
          if (op == OP_MAP)     chan_map[i] <= cfg_val;
        end
      end
      for (int h = 0; h < N_HOST; h++) begin
        if (host_hit[h]) begin
          if (op == OP_HEN_SET) host_en[h] <= 1'b1;
          if (op == OP_HEN_CLR) host_en[h] <= 1'b0;
        end
      end
      if (op == OP_GLB_ON)  glob_en <= 1'b1;
      if (op == OP_GLB_OFF) glob_en <= 1'b0;
    end
  end

  // R9: the all-off command takes effect at the next edge
  p_glb_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && op == OP_GLB_OFF) |=> !glob_en);

  // R8: a host enable clear leaves that host disabled
  p_hen_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HEN_CLR && host_hit != '0) |=> ((host_en & $past(host_hit)) == '0));

  // R7: a system enable set leaves that input enabled
  p_sen_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SEN_SET && sys_hit != '0) |=> ((sys_en & $past(sys_hit)) == $past(sys_hit)));
endmodule

// File: rtl/cic_status.sv
module cic_status #(
  parameter int N_SYS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SYS-1:0] sys_irq,
  input  logic [N_SYS-1:0] clr_vec,
  output logic [N_SYS-1:0] pend,
  output logic [N_SYS-1:0] edge_vec
);
  logic [N_SYS-1:0] prev_q;

  assign edge_vec = sys_irq & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend   <= '0;
    end else begin
      prev_q <= sys_irq;
      pend   <= (pend & ~clr_vec) | edge_vec;
    end
  end

  // R2: an edge always leaves its bit pending
  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_vec != '0) |=> ((pend & $past(edge_vec)) == $past(edge_vec)));

  // R3: a clear with no competing edge drops the bit
  p_clr_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~edge_vec) != '0) |=> ((pend & $past(clr_vec & ~edge_vec)) == '0));

  // R4: edge and clear together keep the bit
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & edge_vec) != '0) |=> ((pend & $past(clr_vec & edge_vec)) == $past(clr_vec & edge_vec)));
endmodule

// File: rtl/cic_route.sv
module cic_route #(
  parameter int N_SYS  = 8,
  parameter int N_HOST = 5,
  parameter int CH_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SYS-1:0]           pend,
  input  logic [N_SYS-1:0]           sys_en,
  input  logic [N_SYS-1:0][CH_W-1:0] chan_map,
  input  logic [N_HOST-1:0]          host_en,
  input  logic                       glob_en,
  output logic [N_HOST-1:0]          chan_hit,
  output logic [N_HOST-1:0]          host_irq
);
  logic [N_SYS-1:0] live;

  function automatic logic [N_SYS-1:0] chan_select(
    input logic [N_SYS-1:0][CH_W-1:0] m, input int h);
    logic [N_SYS-1:0] v;
    for (int i = 0; i < N_SYS; i++) v[i] = (int'(m[i]) == h);
    return v;
  endfunction

  assign live = pend & sys_en;

  for (genvar h = 0; h < N_HOST; h++) begin : g_chan
    assign chan_hit[h] = |(live & chan_select(chan_map, h));
    assign host_irq[h] = glob_en & host_en[h] & chan_hit[h];
  end

  // R9: global off silences everything
  p_glob_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> (host_irq == '0));

  // R8: no output on a disabled host
  p_host_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_irq & ~host_en) == '0));

  // R7: with no enabled pending source, all outputs are low
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> (host_irq == '0));
endmodule

// File: rtl/cic_aggregator.sv
module cic_aggregator #(
  parameter int N_SYS  = 8,
  parameter int N_HOST = 5,
  localparam int CH_W  = $clog2(N_HOST) + ((N_HOST < 2) ? 1 : 0),
  localparam int IDX_W = cic_pkg::max_int($clog2(N_SYS), $clog2(N_HOST)) + ((N_SYS < 2 && N_HOST < 2) ? 1 : 0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SYS-1:0]  sys_irq_i,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_op,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CH_W-1:0]   cfg_val,
  output logic [N_SYS-1:0]  sys_pend_o,
  output logic [N_HOST-1:0] host_irq_o
);
  logic [N_SYS-1:0]           sys_en;
  logic [N_SYS-1:0][CH_W-1:0] chan_map;
  logic [N_HOST-1:0]          host_en;
  logic                       glob_en;
  logic [N_SYS-1:0]           clr_vec;
  logic [N_SYS-1:0]           edge_vec;
  logic [N_HOST-1:0]          chan_hit;

  cic_cfg_regs #(.N_SYS(N_SYS), .N_HOST(N_HOST), .IDX_W(IDX_W), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx),
    .cfg_val(cfg_val), .sys_en(sys_en), .chan_map(chan_map), .host_en(host_en),
    .glob_en(glob_en), .clr_vec(clr_vec));

  cic_status #(.N_SYS(N_SYS)) u_status (
    .clk(clk), .rst_n(rst_n), .sys_irq(sys_irq_i), .clr_vec(clr_vec),
    .pend(sys_pend_o), .edge_vec(edge_vec));

  cic_route #(.N_SYS(N_SYS), .N_HOST(N_HOST), .CH_W(CH_W)) u_route (
    .clk(clk), .rst_n(rst_n), .pend(sys_pend_o), .sys_en(sys_en), .chan_map(chan_map),
    .host_en(host_en), .glob_en(glob_en), .chan_hit(chan_hit), .host_irq(host_irq_o));

  // R1: nothing pending means nothing out
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_pend_o == '0) |-> (host_irq_o == '0));

  // R5: each asserted output has a live channel behind it
  p_out_has_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_irq_o & ~chan_hit) == '0));

  // R2: an edge on the port is visible as pending one edge later
  p_port_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_vec != '0) |=> ((sys_pend_o & $past(edge_vec)) != '0));
endmodule

// File: tb/tb_cic_aggregator.sv
module tb_cic_aggregator;
  localparam int NS = 8;
  localparam int NH = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] sys_irq_i = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_op = '0;
  logic [2:0]    cfg_idx = '0;
  logic [2:0]    cfg_val = '0;
  logic [NS-1:0] sys_pend_o;
  logic [NH-1:0] host_irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [NS-1:0] m_pend = '0, m_en = '0, m_prev = '0, cur = '0;
  logic [NH-1:0] m_hen = '0;
  logic          m_glob = 1'b1;
  int            m_map [NS];

  always #10 clk = ~clk;

  cic_aggregator #(.N_SYS(NS), .N_HOST(NH)) dut (
    .clk(clk), .rst_n(rst_n), .sys_irq_i(sys_irq_i), .cfg_we(cfg_we), .cfg_op(cfg_op),
    .cfg_idx(cfg_idx), .cfg_val(cfg_val), .sys_pend_o(sys_pend_o), .host_irq_o(host_irq_o));

  function automatic logic [NH-1:0] exp_host();
    logic [NH-1:0] v = '0;
    for (int h = 0; h < NH; h++)
      for (int i = 0; i < NS; i++)
        if (m_pend[i] && m_en[i] && m_map[i] == h && m_hen[h] && m_glob) v[h] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag);
    logic [NH-1:0] eh = exp_host();
    n_checks++;
    if (sys_pend_o !== m_pend || host_irq_o !== eh) begin
      n_fail++;
      $display("FAIL %s: pend=%b host=%b expected pend=%b host=%b",
               tag, sys_pend_o, host_irq_o, m_pend, eh);
    end
  endtask

  // Called at a negative edge; applies one cycle of stimulus and checks at the next one.
  task automatic step(input logic we, input int op, input int idx, input int val,
                      input logic [NS-1:0] sin, input string tag);
    logic [NS-1:0] ed, clr;
    cfg_we = we; cfg_op = op[2:0]; cfg_idx = idx[2:0]; cfg_val = val[2:0]; sys_irq_i = sin;
    @(posedge clk);
    ed = sin & ~m_prev;
    m_prev = sin;
    clr = '0;
    if (we) begin
      case (op)
        0: if (idx < NS) m_en[idx] = 1'b1;
        1: if (idx < NS) m_en[idx] = 1'b0;
        2: if (idx < NS) clr[idx] = 1'b1;
        3: if (idx < NS) m_map[idx] = val;
        4: if (idx < NH) m_hen[idx] = 1'b1;
        5: if (idx < NH) m_hen[idx] = 1'b0;
        6: m_glob = 1'b1;
        default: m_glob = 1'b0;
      endcase
    end
    m_pend = (m_pend & ~clr) | ed;
    @(negedge clk);
    cfg_we = 1'b0;
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) m_map[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    step(0, 0, 0, 0, cur, "R1");

    // R1: default channel 0 and global on: only enables are written
    step(1, 0, 0, 0, cur, "R1");
    step(1, 4, 0, 0, cur, "R1");
    cur[0] = 1'b1; step(0, 0, 0, 0, cur, "R1");
    cur[0] = 1'b0; step(1, 2, 0, 0, cur, "R3");
    step(1, 1, 0, 0, cur, "R7");

    for (int h = 1; h < NH; h++) step(1, 4, h, 0, cur, "R8");

    // Sweep every input against every channel code, including unmapped codes
    for (int i = 0; i < NS; i++) begin
      for (int c = 0; c < 8; c++) begin
        step(1, 3, i, c, cur, "R5");
        step(1, 0, i, 0, cur, "R7");
        cur[i] = 1'b1; step(0, 0, 0, 0, cur, "R2");
        cur[i] = 1'b0; step(0, 0, 0, 0, cur, (c >= NH) ? "R10" : "R5");
        step(1, 2, i, 0, cur, "R3");
        step(1, 1, i, 0, cur, "R7");
      end
    end

    // R10: out-of-range host index changes nothing
    step(1, 5, 6, 0, cur, "R10");

    // R6: three inputs share channel 2, retire them one by one
    step(1, 3, 0, 2, cur, "R6"); step(1, 3, 3, 2, cur, "R6"); step(1, 3, 6, 2, cur, "R6");
    step(1, 0, 0, 0, cur, "R6"); step(1, 0, 3, 0, cur, "R6"); step(1, 0, 6, 0, cur, "R6");
    cur = 8'b0100_1001; step(0, 0, 0, 0, cur, "R6");
    cur = '0;           step(0, 0, 0, 0, cur, "R6");
    step(1, 2, 3, 0, cur, "R6");
    step(1, 2, 0, 0, cur, "R6");
    step(1, 2, 6, 0, cur, "R6");

    // R7: disabling a pending source drops the output, pending stays
    cur[3] = 1'b1; step(0, 0, 0, 0, cur, "R7");
    cur[3] = 1'b0; step(1, 1, 3, 0, cur, "R7");
    step(1, 0, 3, 0, cur, "R7");

    // R8: host enable gating
    step(1, 5, 2, 0, cur, "R8");
    step(1, 4, 2, 0, cur, "R8");

    // R9: global off and back on
    step(1, 7, 0, 0, cur, "R9");
    step(0, 0, 0, 0, cur, "R9");
    step(1, 6, 0, 0, cur, "R9");
    step(1, 2, 3, 0, cur, "R3");

    // R4: clear on the same edge as a new input edge
    cur[6] = 1'b1; step(1, 2, 6, 0, cur, "R4");
    // R2: held-high line cleared stays clear
    step(1, 2, 6, 0, cur, "R2");
    step(0, 0, 0, 0, cur, "R2");
    cur[6] = 1'b0; step(0, 0, 0, 0, cur, "R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule